// File: doc/BRIEF.md
# Binary Min-Max Check Node Unit

This unit produces the outgoing check-to-variable messages of one degree-6 parity check in a binary min-max decoder. Every edge carries a pair of unsigned costs: one for the bit being 0 and one for the bit being 1. A start pulse latches all six incoming messages at once. The unit then works through the six outgoing edges in turn, from edge 0 to edge 5.

For each outgoing edge, the unit steps through all 32 bit assignments of the five other edges, one assignment per clock. For each assignment it takes the largest of the selected costs. When the five bits have even parity, that maximum is a candidate for the bit-0 result. When they have odd parity, it is a candidate for the bit-1 result. Each result is the smallest of its 16 candidates.

Each finished edge appears on the output for one cycle, with a valid pulse and its edge index. A done pulse comes with the last edge. The caller must hold its message storage until done, and then may start the next check node straight away.

Top module: `cnu_minmax_top`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, out_valid_o and done_o are low.
- R2: When start_i is sampled high while busy_o is low, the unit latches msg_c0_i and msg_c1_i, and busy_o is high from the next cycle on.
- R3: For outgoing edge e, out_cost0_o equals the minimum, over the 16 assignments of bits to the other five edges with even parity, of the maximum of the selected costs. Edge i occupies bits [6i+5:6i] of each message bus, and a bit of 0 selects msg_c0_i while a bit of 1 selects msg_c1_i.
- R4: out_cost1_o is computed the same way over the 16 assignments with odd parity.
- R5: Results are issued in edge order 0, 1, 2, 3, 4, 5, with out_edge_o giving the index, and exactly six are issued for each start.
- R6: The first result is valid 32 cycles after the start edge, and each later result follows 32 cycles after the one before it.
- R7: done_o is high for one cycle, in the same cycle as the edge-5 result, and busy_o is low from that cycle on.
- R8: While busy_o is high, start_i and any change on the message inputs have no effect on the results.
- R9: out_valid_o is high for a single cycle per result, and out_cost0_o and out_cost1_o hold their value until the next result.
- R10: Costs are 6-bit unsigned values. Comparisons are unsigned, so costs of 63 give results of 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch the messages and begin a check node |
| msg_c0_i | input | 36 | Bit-0 costs of the six incoming edges, 6 bits each |
| msg_c1_i | input | 36 | Bit-1 costs of the six incoming edges, 6 bits each |
| busy_o | output | 1 | A check node is being processed |
| out_valid_o | output | 1 | Result for one edge is present |
| out_edge_o | output | 3 | Index of the edge being reported |
| out_cost0_o | output | 6 | Outgoing bit-0 cost |
| out_cost1_o | output | 6 | Outgoing bit-1 cost |
| done_o | output | 1 | Last edge of the check node is being reported |

## Verification
A wrong assignment counter or edge counter shows up within one 32-cycle sweep: a result arrives at the wrong cycle, with the wrong edge index, or with costs that follow the wrong parity. A bad running minimum, or a missed clear between edges, makes a cost differ from the brute-force model at the next result. Varied message patterns, saturated costs, and a start arriving mid-run expose errors in input selection and in latching, each at the first affected edge.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cnu_state_e;
endpackage

// File: rtl/cnu_cfg_sel.sv
// Maps (outgoing edge, assignment index) to a per-input cost select and an include mask.
module cnu_cfg_sel #(
  parameter int DEG  = 6,
  parameter int EW   = 3,
  parameter int CFGW = 5
) (
  input  logic [EW-1:0]   edge_i,
  input  logic [CFGW-1:0] cfg_i,
  output logic [DEG-1:0]  sel_o,
  output logic [DEG-1:0]  use_o
);
  for (genvar g = 0; g < DEG; g++) begin : g_in
    localparam logic [EW-1:0] GI = EW'(g);
    logic lo_bit, hi_bit;
    if (g < CFGW) begin : g_lo
      assign lo_bit = cfg_i[g];
    end else begin : g_lo_none
      assign lo_bit = 1'b0;
    end
    if (g > 0) begin : g_hi
      assign hi_bit = cfg_i[g-1];
    end else begin : g_hi_none
      assign hi_bit = 1'b0;
    end
    assign use_o[g] = (edge_i != GI);
    assign sel_o[g] = (GI < edge_i) ? lo_bit : hi_bit;
  end

  always_comb begin
    if (edge_i < EW'(DEG))
      AST_ONE_EXCLUDED: assert ($countones(use_o) == DEG - 1); // R3
  end
endmodule

// File: rtl/cnu_max_sel.sv
// Largest selected cost over the included inputs.
module cnu_max_sel #(
  parameter int DEG = 6,
  parameter int W   = 6
) (
  input  logic [DEG*W-1:0] c0_i,
  input  logic [DEG*W-1:0] c1_i,
  input  logic [DEG-1:0]   sel_i,
  input  logic [DEG-1:0]   use_i,
  output logic [W-1:0]     max_o
);
  logic [W-1:0] pick [DEG];

  for (genvar g = 0; g < DEG; g++) begin : g_pick
    assign pick[g] = !use_i[g] ? '0 :
                     (sel_i[g] ? c1_i[g*W +: W] : c0_i[g*W +: W]);
  end

  always_comb begin
    max_o = '0;
    for (int i = 0; i < DEG; i++) begin
      if (pick[i] > max_o) max_o = pick[i];
    end
  end
endmodule

// File: rtl/cnu_min_acc.sv
// Running minima for even and odd parity across one sweep.
module cnu_min_acc #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         odd_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] nxt_even_o,
  output logic [W-1:0] nxt_odd_o
);
  logic [W-1:0] acc_even_q, acc_odd_q;
  logic [W-1:0] base_even, base_odd;

  always_comb begin
    base_even  = clr_i ? '1 : acc_even_q;
    base_odd   = clr_i ? '1 : acc_odd_q;
    nxt_even_o = base_even;
    nxt_odd_o  = base_odd;
    if (!odd_i && val_i < base_even) nxt_even_o = val_i;
    if (odd_i && val_i < base_odd)   nxt_odd_o  = val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_even_q <= '1;
      acc_odd_q  <= '1;
    end else if (en_i) begin
      acc_even_q <= nxt_even_o;
      acc_odd_q  <= nxt_odd_o;
    end
  end

  AST_MIN_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (nxt_even_o <= acc_even_q && nxt_odd_o <= acc_odd_q)); // R3
endmodule

// File: rtl/cnu_minmax_top.sv
module cnu_minmax_top #(
  parameter int DEG    = 6,
  parameter int COST_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [DEG*COST_W-1:0] msg_c0_i,
  input  logic [DEG*COST_W-1:0] msg_c1_i,
  output logic                  busy_o,
  output logic                  out_valid_o,
  output logic [$clog2(DEG)-1:0] out_edge_o,
  output logic [COST_W-1:0]     out_cost0_o,
  output logic [COST_W-1:0]     out_cost1_o,
  output logic                  done_o
);
  import cnu_pkg::*;

  localparam int EW   = $clog2(DEG);
  localparam int CFGW = DEG - 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(DEG - 1);

  cnu_state_e          state_q;
  logic [EW-1:0]       edge_q;
  logic [CFGW-1:0]     cfg_q;
  logic [DEG*COST_W-1:0] c0_q, c1_q;
  logic [DEG-1:0]      sel, use_m;
  logic [COST_W-1:0]   cfg_max, nxt_even, nxt_odd;
  logic                run, cfg_last;

  assign run      = (state_q == ST_RUN);
  assign cfg_last = (cfg_q == '1);
  assign busy_o   = run;

  cnu_cfg_sel #(.DEG(DEG), .EW(EW), .CFGW(CFGW)) u_cfg_sel (
    .edge_i (edge_q),
    .cfg_i  (cfg_q),
    .sel_o  (sel),
    .use_o  (use_m)
  );

  cnu_max_sel #(.DEG(DEG), .W(COST_W)) u_max_sel (
    .c0_i  (c0_q),
    .c1_i  (c1_q),
    .sel_i (sel),
    .use_i (use_m),
    .max_o (cfg_max)
  );

  cnu_min_acc #(.W(COST_W)) u_min_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run),
    .clr_i      (cfg_q == '0),
    .odd_i      (^cfg_q),
    .val_i      (cfg_max),
    .nxt_even_o (nxt_even),
    .nxt_odd_o  (nxt_odd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      cfg_q   <= '0;
      c0_q    <= '0;
      c1_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          edge_q  <= '0;
          cfg_q   <= '0;
          c0_q    <= msg_c0_i;
          c1_q    <= msg_c1_i;
        end
        ST_RUN: begin
          cfg_q <= cfg_q + 1'b1;
          if (cfg_last) begin
            if (edge_q == LAST_EDGE) state_q <= ST_IDLE;
            else edge_q <= edge_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      out_edge_o  <= '0;
      out_cost0_o <= '0;
      out_cost1_o <= '0;
    end else begin
      out_valid_o <= run && cfg_last;
      done_o      <= run && cfg_last && (edge_q == LAST_EDGE);
      if (run && cfg_last) begin
        out_edge_o  <= edge_q;
        out_cost0_o <= nxt_even;
        out_cost1_o <= nxt_odd;
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && out_edge_o == LAST_EDGE && !busy_o)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !out_valid_o); // R9
  AST_COST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(out_cost0_o) && $stable(out_cost1_o))); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(c0_q) && $stable(c1_q))); // R8
endmodule

// File: tb/cnu_minmax_top_bench.sv
module cnu_minmax_top_bench;
  localparam int DEG = 6;
  localparam int W   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DEG*W-1:0] m0 = '0, m1 = '0;
  logic busy, vld, done;
  logic [2:0] edge_idx;
  logic [W-1:0] oc0, oc1;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  cnu_minmax_top u_cnu_minmax_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .msg_c0_i(m0), .msg_c1_i(m1),
    .busy_o(busy), .out_valid_o(vld), .out_edge_o(edge_idx),
    .out_cost0_o(oc0), .out_cost1_o(oc1), .done_o(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Brute force over all six bits: own bit b, overall parity even.
  function automatic int ref_cost(input logic [DEG*W-1:0] a0, input logic [DEG*W-1:0] a1,
                                  input int e, input int b);
    int best = 64;
    for (int a = 0; a < 64; a++) begin
      int m = 0, ones = 0;
      if (((a >> e) & 1) != b) continue;
      for (int i = 0; i < DEG; i++) ones += (a >> i) & 1;
      if (ones % 2 != 0) continue;
      for (int i = 0; i < DEG; i++) begin
        int v;
        if (i == e) continue;
        v = ((a >> i) & 1) ? int'(a1[i*W +: W]) : int'(a0[i*W +: W]);
        if (v > m) m = v;
      end
      if (m < best) best = m;
    end
    return best;
  endfunction

  task automatic run_case(input logic [DEG*W-1:0] a0, input logic [DEG*W-1:0] a1,
                          input string tag, input bit disturb);
    int ne = 0;
    @(negedge clk);
    start = 1'b1; m0 = a0; m1 = a1;
    for (int i = 1; i <= 194; i++) begin
      @(negedge clk);
      if (i == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after start ", tag}, busy, 1);
      end
      if (disturb && i == 5) begin start = 1'b1; m0 = ~a0; m1 = ~a1; end
      if (disturb && i == 40) start = 1'b0;
      if (vld) begin
        chk(i == 33 + 32 * ne, {"R6 result timing ", tag}, i, 33 + 32 * ne);
        chk(int'(edge_idx) == ne, {"R5 edge order ", tag}, edge_idx, ne);
        chk(int'(oc0) == ref_cost(a0, a1, ne, 0), {"R3 cost0 ", tag}, oc0, ref_cost(a0, a1, ne, 0));
        chk(int'(oc1) == ref_cost(a0, a1, ne, 1), {"R4 cost1 ", tag}, oc1, ref_cost(a0, a1, ne, 1));
        chk(done == (ne == 5), {"R7 done with last ", tag}, done, ne == 5);
        ne++;
      end else if (i != 194) begin
        chk(done == 1'b0, {"R7 done stray ", tag}, done, 0);
      end
      if (i == 193) chk(busy == 1'b0, {"R7 busy drop ", tag}, busy, 0);
      if (i == 194) begin
        chk(vld == 1'b0 && done == 1'b0, {"R9 single pulse ", tag}, vld, 0);
        chk(int'(oc0) == ref_cost(a0, a1, 5, 0), {"R9 cost hold ", tag}, oc0, ref_cost(a0, a1, 5, 0));
      end
    end
    chk(ne == 6, {"R5 result count ", tag}, ne, 6);
    m0 = '0; m1 = '0;
  endtask

  task automatic t_reset();
    chk(busy == 0 && vld == 0 && done == 0, "R1 in reset", {busy, vld, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && vld == 0 && done == 0, "R1 after reset", {busy, vld, done}, 0);
  endtask

  task automatic t_zero();      run_case('0, '0, "zero", 1'b0); endtask
  task automatic t_saturate();  run_case('1, '1, "R10 saturate", 1'b0); endtask

  task automatic t_skew();
    logic [DEG*W-1:0] a1;
    for (int i = 0; i < DEG; i++) a1[i*W +: W] = W'(7 * i + 20);
    run_case('0, a1, "skew", 1'b0);
  endtask

  task automatic t_random(input int n);
    for (int k = 0; k < n; k++) begin
      logic [DEG*W-1:0] a0, a1;
      for (int i = 0; i < DEG; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223; a0[i*W +: W] = lcg[29:24];
        lcg = lcg * 32'd1664525 + 32'd1013904223; a1[i*W +: W] = lcg[29:24];
      end
      run_case(a0, a1, "random", 1'b0);
    end
  endtask

  task automatic t_busy_start();
    run_case(36'h0F3_2A1_C57, 36'h3E1_04B_9D2, "R8 start while busy", 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_saturate();
    t_skew();
    t_random(4);
    t_busy_start();
    t_random(1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule